// File: doc/BRIEF.md
# Multi-Bank Clock Divider

This block divides one fast source clock into three output banks of identical-phase clocks and one feedback clock. Every bank takes its ratio from a small select field, and one shared range bit doubles every ratio in the block at once. All ratios are even, so each output spends exactly half of its period high and half low.

The dividers share one start point: when the active-low master control is released, every counter starts from zero on the same source edge, so rising edges coincide whenever the ratios allow it. While the master control is low the block holds all dividers cleared, drives every output low and drops its output-enable flag, which the pad ring uses to float the pins. Select inputs are sampled only while the master control is low; the value present on the last low cycle is the one used for the whole following run. The upper half of bank C can be shifted by half a period relative to its lower half.

The sequencer has two states. HOLD is entered from any state when the master control is sampled low (transition ABORT) and is the state after power-up once the control has been low for one edge. RUN is entered from HOLD on the first edge with the master control high (transition RELEASE) and stays there while the control remains high (transition KEEP). HOLD also loops on itself while the control is low (transition WAIT), and the configuration is captured on every WAIT or ABORT edge.

Top module: `clkdiv_banks`

## Requirements
- R1: Bank A divides the source by 4, 6, 8 or 12 for select codes 0, 1, 2, 3 when the range bit is 1, and by twice those values when it is 0.
- R2: Bank B divides the source by 4, 6, 8 or 10 for select codes 0 to 3 when the range bit is 1, and by twice those values when it is 0.
- R3: Bank C divides the source by 2, 4, 6 or 8 for select codes 0 to 3 when the range bit is 1, and by twice those values when it is 0.
- R4: The feedback clock uses a 3-bit select; its low two bits pick 4, 6, 8 or 10 and bit 2 set doubles that, all with the range bit at 1; a range bit of 0 doubles the result again, up to 40.
- R5: Each output with divisor N is high for N/2 source cycles and then low for N/2 source cycles, repeating.
- R6: In the first cycle after release every output of every bank and the feedback clock is high, and each counter restarts its period on that same edge.
- R7: With the invert bit at 1, bank C outputs 2 and 3 are the complement of outputs 0 and 1 while running; with it at 0, all four are equal.
- R8: When the master control is sampled low at a rising source edge, from the next cycle onward the output-enable flag is 0 and every clock output is 0.
- R9: Range, bank selects, feedback select and invert bit are taken from the last edge at which the master control was sampled low; changes while running, including on the release edge itself, have no effect until the next hold.
- R10: The output-enable flag is 1 from the first cycle after release and stays 1 as long as the master control is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| hold_n | input | 1 | Active-low master reset and output disable, sampled on the rising edge |
| range_hi | input | 1 | Range bit: 1 uses base ratios, 0 doubles all ratios |
| sel_a | input | 2 | Bank A ratio select |
| sel_b | input | 2 | Bank B ratio select |
| sel_c | input | 2 | Bank C ratio select |
| sel_fb | input | 3 | Feedback ratio select |
| inv_c_hi | input | 1 | Invert bank C outputs 2 and 3 |
| bank_a | output | BANK_W | Bank A clocks |
| bank_b | output | BANK_W | Bank B clocks |
| bank_c | output | BANK_W | Bank C clocks |
| fb_clk | output | 1 | Feedback clock |
| out_en | output | 1 | Output-enable flag, high while running |

## Verification
Two things can land on the same edge: the release of the master control and a change of the select inputs. The bench drives new selects in the same half cycle that it raises the control, and expects the outputs to follow the selects that were present during the hold, not the new ones. It also drops the control on a cycle where a divider finishes its period, and expects the block to go quiet on the next cycle rather than start another high phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int DIV_CNT_W = 6;
    localparam int NUM_DIV   = 4;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic       range_hi;
        logic [1:0] sel_a;
        logic [1:0] sel_b;
        logic [1:0] sel_c;
        logic [2:0] sel_fb;
        logic       inv_c_hi;
    } div_cfg_t;

    // divider kinds
    localparam int KIND_A  = 0;
    localparam int KIND_B  = 1;
    localparam int KIND_C  = 2;
    localparam int KIND_FB = 3;

    // ratio with range bit at 1
    function automatic int base_ratio(input int kind, input logic [2:0] code);
        int step;
        step = int'(code[1:0]);
        case (kind)
            KIND_A:  return (step == 3) ? 12 : 4 + 2 * step;
            KIND_B:  return 4 + 2 * step;
            KIND_C:  return 2 + 2 * step;
            default: return (4 + 2 * step) << int'(code[2]);
        endcase
    endfunction

    function automatic int full_ratio(input int kind, input logic [2:0] code,
                                      input logic range_hi);
        int r;
        r = base_ratio(kind, code);
        return range_hi ? r : 2 * r;
    endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
(
    input  logic       clk_src,
    input  logic       hold_n,
    input  div_cfg_t   cfg_in,
    output div_cfg_t   cfg_q,
    output logic       start,
    output logic       running,
    output logic       out_en
);

    run_state_e state_q;
    run_state_e state_d;

    // next-state: WAIT, RELEASE, KEEP, ABORT
    always_comb begin
        unique case (state_q)
            ST_HOLD: state_d = hold_n ? ST_RUN  : ST_HOLD;
            ST_RUN:  state_d = hold_n ? ST_RUN  : ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk_src) begin
        state_q <= state_d;
        if (!hold_n) begin
            cfg_q <= cfg_in;
        end
    end

    // outputs of the sequencer
    always_comb begin
        start   = 1'b0;
        running = 1'b0;
        out_en  = 1'b0;
        unique case (state_q)
            ST_HOLD: start = hold_n;
            ST_RUN: begin
                running = hold_n;
                out_en  = 1'b1;
            end
            default: begin
                start   = 1'b0;
                running = 1'b0;
                out_en  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk_src,
    input  logic             hold_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] ratio,
    output logic             q
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] half;
    logic             last;

    always_comb begin
        half    = ratio >> 1;
        last    = (cnt_q == ratio - CNT_W'(1));
        cnt_nxt = last ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_src) begin
        if (!hold_n) begin
            cnt_q <= '0;
            q     <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            q     <= 1'b1;
        end else if (run) begin
            cnt_q <= cnt_nxt;
            q     <= (cnt_nxt < half);
        end
    end

endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
    import clkdiv_pkg::*;
#(
    parameter int BANK_W = 4,
    parameter int CNT_W  = DIV_CNT_W
) (
    input  logic              clk_src,
    input  logic              hold_n,
    input  logic              range_hi,
    input  logic [1:0]        sel_a,
    input  logic [1:0]        sel_b,
    input  logic [1:0]        sel_c,
    input  logic [2:0]        sel_fb,
    input  logic              inv_c_hi,
    output logic [BANK_W-1:0] bank_a,
    output logic [BANK_W-1:0] bank_b,
    output logic [BANK_W-1:0] bank_c,
    output logic              fb_clk,
    output logic              out_en
);

    localparam int HALF_W = BANK_W / 2;

    div_cfg_t         cfg_in;
    div_cfg_t         cfg_q;
    logic             start;
    logic             running;
    logic [2:0]       code   [NUM_DIV];
    logic [CNT_W-1:0] ratio  [NUM_DIV];
    logic [NUM_DIV-1:0] div_q;

    always_comb begin
        cfg_in.range_hi = range_hi;
        cfg_in.sel_a    = sel_a;
        cfg_in.sel_b    = sel_b;
        cfg_in.sel_c    = sel_c;
        cfg_in.sel_fb   = sel_fb;
        cfg_in.inv_c_hi = inv_c_hi;
    end

    clkdiv_ctrl u_ctrl (
        .clk_src (clk_src),
        .hold_n  (hold_n),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .start   (start),
        .running (running),
        .out_en  (out_en)
    );

    always_comb begin
        code[KIND_A]  = {1'b0, cfg_q.sel_a};
        code[KIND_B]  = {1'b0, cfg_q.sel_b};
        code[KIND_C]  = {1'b0, cfg_q.sel_c};
        code[KIND_FB] = cfg_q.sel_fb;
    end

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        always_comb begin
            ratio[g] = CNT_W'(full_ratio(g, code[g], cfg_q.range_hi));
        end

        clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_src (clk_src),
            .hold_n  (hold_n),
            .start   (start),
            .run     (running),
            .ratio   (ratio[g]),
            .q       (div_q[g])
        );
    end

    logic c_hi_bit;

    always_comb begin
        c_hi_bit = div_q[KIND_C] ^ cfg_q.inv_c_hi;
        bank_a   = {BANK_W{div_q[KIND_A] & out_en}};
        bank_b   = {BANK_W{div_q[KIND_B] & out_en}};
        bank_c   = {{(BANK_W - HALF_W){c_hi_bit & out_en}},
                    {HALF_W{div_q[KIND_C] & out_en}}};
        fb_clk   = div_q[KIND_FB] & out_en;
    end

endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk #(
    parameter int BANK_W = 4
) (
    input logic              clk_src,
    input logic              hold_n,
    input logic [BANK_W-1:0] bank_a,
    input logic [BANK_W-1:0] bank_b,
    input logic [BANK_W-1:0] bank_c,
    input logic              fb_clk,
    input logic              out_en
);

    localparam int HALF_W = BANK_W / 2;

    assert_quiet_off_R8: assert property (@(posedge clk_src) disable iff (!hold_n)
        !out_en |-> (bank_a == '0 && bank_b == '0 && bank_c == '0 && !fb_clk));

    assert_aligned_rise_R6: assert property (@(posedge clk_src) disable iff (!hold_n)
        $rose(out_en) |-> (bank_a[0] && bank_b[0] && bank_c[0] && fb_clk));

    assert_en_sticky_R10: assert property (@(posedge clk_src) disable iff (!hold_n)
        out_en |=> out_en);

    assert_a_min_half_R1: assert property (@(posedge clk_src) disable iff (!hold_n)
        (out_en && !$stable(bank_a[0])) |=> $stable(bank_a[0]));

    assert_fb_min_half_R4: assert property (@(posedge clk_src) disable iff (!hold_n)
        (out_en && !$stable(fb_clk)) |=> $stable(fb_clk));

    assert_c_pairs_R7: assert property (@(posedge clk_src) disable iff (!hold_n)
        out_en |-> (bank_c[BANK_W-1] == bank_c[HALF_W] && bank_c[HALF_W-1] == bank_c[0]));

endmodule

bind clkdiv_banks clkdiv_banks_chk #(.BANK_W(BANK_W)) u_chk (
    .clk_src (clk_src),
    .hold_n  (hold_n),
    .bank_a  (bank_a),
    .bank_b  (bank_b),
    .bank_c  (bank_c),
    .fb_clk  (fb_clk),
    .out_en  (out_en)
);

// File: tb/sim_clkdiv_banks.sv
`timescale 1ns/1ps
module sim_clkdiv_banks;

    localparam int BW = 4;
    localparam int RUN_CYC = 84;

    logic          clk_src = 1'b0;
    logic          hold_n = 1'b0;
    logic          range_hi = 1'b1;
    logic [1:0]    sel_a = '0;
    logic [1:0]    sel_b = '0;
    logic [1:0]    sel_c = '0;
    logic [2:0]    sel_fb = '0;
    logic          inv_c_hi = 1'b0;
    logic [BW-1:0] bank_a;
    logic [BW-1:0] bank_b;
    logic [BW-1:0] bank_c;
    logic          fb_clk;
    logic          out_en;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk_src = ~clk_src;

    clkdiv_banks #(.BANK_W(BW)) u0 (
        .clk_src(clk_src), .hold_n(hold_n), .range_hi(range_hi),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_fb(sel_fb),
        .inv_c_hi(inv_c_hi), .bank_a(bank_a), .bank_b(bank_b),
        .bank_c(bank_c), .fb_clk(fb_clk), .out_en(out_en)
    );

    // {range, sel_a, sel_b, sel_c, sel_fb, inv}
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 2'b00, 2'b00, 2'b00, 3'b000, 1'b0},
        {1'b1, 2'b01, 2'b11, 2'b10, 3'b011, 1'b1},
        {1'b1, 2'b11, 2'b10, 2'b01, 3'b111, 1'b0},
        {1'b0, 2'b00, 2'b01, 2'b11, 3'b100, 1'b1},
        {1'b0, 2'b11, 2'b11, 2'b00, 3'b010, 1'b0},
        {1'b0, 2'b10, 2'b00, 2'b10, 3'b111, 1'b1},
        {1'b1, 2'b10, 2'b01, 2'b11, 3'b101, 1'b1},
        {1'b0, 2'b01, 2'b10, 2'b01, 3'b001, 1'b0}
    };

    function automatic int exp_a(input logic r, input logic [1:0] s);
        int t;
        case (s) 2'd0: t = 4; 2'd1: t = 6; 2'd2: t = 8; default: t = 12; endcase
        return r ? t : t * 2;
    endfunction
    function automatic int exp_b(input logic r, input logic [1:0] s);
        int t;
        case (s) 2'd0: t = 4; 2'd1: t = 6; 2'd2: t = 8; default: t = 10; endcase
        return r ? t : t * 2;
    endfunction
    function automatic int exp_c(input logic r, input logic [1:0] s);
        int t;
        case (s) 2'd0: t = 2; 2'd1: t = 4; 2'd2: t = 6; default: t = 8; endcase
        return r ? t : t * 2;
    endfunction
    function automatic int exp_fb(input logic r, input logic [2:0] s);
        int t;
        case (s[1:0]) 2'd0: t = 4; 2'd1: t = 6; 2'd2: t = 8; default: t = 10; endcase
        if (s[2]) t = t * 2;
        return r ? t : t * 2;
    endfunction
    function automatic logic phase(input int n, input int k);
        return (k % n) < (n / 2);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input logic [10:0] v);
        {range_hi, sel_a, sel_b, sel_c, sel_fb, inv_c_hi} = v;
    endtask

    task automatic hold_with(input logic [10:0] v);
        @(negedge clk_src);
        set_cfg(v);
        hold_n = 1'b0;
        repeat (2) @(negedge clk_src);
    endtask

    // samples k cycles after release against configuration v
    task automatic run_and_check(input logic [10:0] v, input int cycles);
        logic r, inv, ea, eb, ec, ef;
        r = v[10];
        inv = v[0];
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk_src);
            ea = phase(exp_a(r, v[9:8]), k);
            eb = phase(exp_b(r, v[7:6]), k);
            ec = phase(exp_c(r, v[5:4]), k);
            ef = phase(exp_fb(r, v[3:1]), k);
            check("R1 R5 R6 bank_a", int'(bank_a), int'({BW{ea}}));
            check("R2 R5 bank_b", int'(bank_b), int'({BW{eb}}));
            check("R3 R7 bank_c", int'(bank_c), int'({{2{ec ^ inv}}, {2{ec}}}));
            check("R4 R5 fb_clk", int'(fb_clk), int'(ef));
            check("R10 out_en", int'(out_en), 1);
        end
    endtask

    task automatic check_quiet(input string tag);
        check(tag, int'({bank_a, bank_b, bank_c, fb_clk, out_en}), 0);
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // reset state, R8
        repeat (3) @(negedge clk_src);
        check_quiet("R8 reset state");

        // table walk
        for (int i = 0; i < 8; i++) begin
            hold_with(VEC[i]);
            check_quiet("R8 held between vectors");
            hold_n = 1'b1;
            run_and_check(VEC[i], RUN_CYC);
        end

        // R9: selects changed while running are ignored
        hold_with(VEC[1]);
        hold_n = 1'b1;
        run_and_check(VEC[1], 7);
        set_cfg(VEC[5]);
        begin
            logic r, ea, ec;
            r = VEC[1][10];
            for (int k = 7; k < 40; k++) begin
                @(negedge clk_src);
                ea = phase(exp_a(r, VEC[1][9:8]), k);
                ec = phase(exp_c(r, VEC[1][5:4]), k);
                check("R9 running change bank_a", int'(bank_a), int'({BW{ea}}));
                check("R9 running change bank_c", int'(bank_c),
                      int'({{2{ec ^ VEC[1][0]}}, {2{ec}}}));
            end
        end

        // R9: new selects on the release edge itself are ignored
        hold_with(VEC[2]);
        hold_n = 1'b1;
        set_cfg(VEC[3]);
        run_and_check(VEC[2], 30);

        // R9: change during hold applies on the next run
        hold_with(VEC[2]);
        set_cfg(VEC[6]);
        @(negedge clk_src);
        hold_n = 1'b1;
        run_and_check(VEC[6], 30);

        // R8: drop control on a cycle where bank C (ratio 2) wraps
        hold_with(VEC[0]);
        hold_n = 1'b1;
        run_and_check(VEC[0], 4);
        hold_n = 1'b0;
        @(negedge clk_src);
        check_quiet("R8 hold during wrap");
        @(negedge clk_src);
        check_quiet("R8 hold persists");

        // R6: restart after abort realigns all outputs
        hold_n = 1'b1;
        @(negedge clk_src);
        check("R6 restart all high", int'({bank_a[0], bank_b[0], bank_c[0], fb_clk}), 4'hF);

        report();
    end

endmodule